// File: doc/BRIEF.md
# Linked-List DMA Element Engine

This block performs the data movement of a multi-channel DMA controller, one element at a time. An outside arbiter picks a channel and pulses a grant with its index. The engine then reads one element from that channel's source address over a single-beat memory master port and writes it to the channel's destination address. It advances the addresses and decrements the transfer count held in the channel's control word.

When a channel's count runs out, the engine does one of two things. If the channel's link pointer is nonzero, it reloads the channel from a four-word descriptor in memory, so transfers can be chained. If the pointer is zero, it switches the channel off. A control-word flag asks for a one-cycle terminal-count pulse on that channel's bit when the count runs out. A memory error response stops the element, disables the channel and pulses that channel's error bit.

Software reaches every channel register through a simple write/read port with a one-cycle read latency.

Top module: `lldma_engine`

## Requirements
- R1: After reset, busy, mem_req, tc_set and err_set are low, every chan_en bit is 0, and every channel register reads back as zero.
- R2: A grant is taken only while the engine is idle, the channel is enabled and its count (control bits [11:0]) is nonzero. Any other grant starts no memory access, leaves busy low and changes no register.
- R3: One grant moves exactly one element: one read at the source address, then one write at the destination address. The source size code is taken from control[20:18] and the destination size code from control[23:21]. Codes 0, 1 and 2 select 1, 2 and 4 bytes, and any larger code is treated as 4 bytes. Data lies in the low bytes of the word, and when both sizes are equal the written bytes equal the read bytes.
- R4: After the element, the source address grows by the source byte count if control bit 26 is set. The destination address grows by the destination byte count if control bit 27 is set. A cleared bit leaves that address unchanged.
- R5: After each element, control bits [11:0] hold the old count minus one and bits [31:12] are unchanged.
- R6: When the count reaches zero and the link pointer is nonzero, the engine reads four 4-byte words in the order pointer+0, pointer+4, pointer+12, pointer+8. These load source, destination, control and the new link pointer, and the channel stays enabled.
- R7: When the count reaches zero and the link pointer is zero, the channel's enable bit is cleared.
- R8: When the count reaches zero and bit 31 of the finishing control word is set, tc_set pulses that channel's bit for exactly one cycle. With bit 31 clear it stays low.
- R9: A mem_err returned with mem_ack ends the grant at once. The channel's enable bit is cleared, err_set pulses that channel's bit for one cycle, no further memory access is made and the count is not decremented.
- R10: Register select codes are 0 source, 1 destination, 2 link pointer, 3 control and 4 enable (bit 0). cfg_rdata shows the register chosen one clock earlier. A write to the channel being serviced while busy is dropped, and writes to other channels take effect.
- R11: busy is high from an accepted grant until the engine is idle again. mem_req is never high while idle, and a raised request keeps its address and direction until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant_valid | input | 1 | Request to service one element of grant_chan |
| grant_chan | input | CHW | Channel index of the grant |
| busy | output | 1 | Engine is servicing a channel |
| cfg_we | input | 1 | Software register write strobe |
| cfg_chan | input | CHW | Channel addressed by software |
| cfg_sel | input | 3 | Register select (0 src, 1 dst, 2 link, 3 ctrl, 4 enable) |
| cfg_wdata | input | 32 | Software write data |
| cfg_rdata | output | 32 | Registered read data of the selected register |
| chan_en | output | NCH | Enable bit of every channel |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| mem_wdata | output | 32 | Write data, low bytes significant |
| mem_rdata | input | 32 | Read data, low bytes significant, little-endian |
| mem_ack | input | 1 | Completion of the current access |
| mem_err | input | 1 | Error response, valid with mem_ack |
| tc_set | output | NCH | One-cycle terminal-count pulse per channel |
| err_set | output | NCH | One-cycle error pulse per channel |

## Verification
The assertions assume a memory slave that pulses mem_ack for a single cycle, only while mem_req is high. They also assume software never writes a channel in the same cycle a grant for that channel is taken. The bench memory model acks one cycle after it sees a request and drops the ack on the next cycle. The stimulus spaces its register writes apart from grants, except in the directed case that writes into the channel already being serviced. Random cases use aligned addresses inside the model's range, sizes 0 to 2 and counts of at least two, so no random grant ends a chain by surprise.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  localparam int DW        = 32;
  localparam int CNT_W     = 12;
  localparam int SSZ_LSB   = 18;
  localparam int DSZ_LSB   = 21;
  localparam int SINC_BIT  = 26;
  localparam int DINC_BIT  = 27;
  localparam int TCF_BIT   = 31;

  typedef enum logic [3:0] {
    ST_IDLE, ST_READ, ST_WRITE, ST_UPDATE,
    ST_FETCH0, ST_FETCH1, ST_FETCH2, ST_FETCH3, ST_DONE
  } lldma_state_e;

  typedef enum logic [2:0] {
    SEL_SRC = 3'd0, SEL_DST = 3'd1, SEL_LINK = 3'd2,
    SEL_CTRL = 3'd3, SEL_EN = 3'd4
  } lldma_sel_e;

  function automatic logic [1:0] clamp_size(input logic [2:0] f);
    return (f > 3'd2) ? 2'd2 : f[1:0];
  endfunction

  function automatic logic [DW-1:0] size_bytes(input logic [1:0] c);
    return DW'(1) << c;
  endfunction
endpackage

// File: rtl/lldma_lane.sv
module lldma_lane
  import lldma_pkg::*;
(
  input  logic [1:0]    size_code,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_comb begin
    case (size_code)
      2'd0:    dout = {{(DW-8){1'b0}},  din[7:0]};
      2'd1:    dout = {{(DW-16){1'b0}}, din[15:0]};
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/lldma_regfile.sv
module lldma_regfile
  import lldma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 32,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sw_we,
  input  logic [CHW-1:0] sw_ch,
  input  logic [2:0]     sw_sel,
  input  logic [DW-1:0]  sw_wdata,
  output logic [DW-1:0]  sw_rdata,
  input  logic           busy,
  input  logic [CHW-1:0] act_ch,
  input  logic [CHW-1:0] look_ch,
  output logic [AW-1:0]  look_src,
  output logic [AW-1:0]  look_dst,
  output logic [AW-1:0]  look_lli,
  output logic [DW-1:0]  look_ctrl,
  output logic           look_en,
  output logic [NCH-1:0] en_vec,
  input  logic           eng_we_src,
  input  logic [AW-1:0]  eng_src,
  input  logic           eng_we_dst,
  input  logic [AW-1:0]  eng_dst,
  input  logic           eng_we_ctrl,
  input  logic [DW-1:0]  eng_ctrl,
  input  logic           eng_we_lli,
  input  logic [AW-1:0]  eng_lli,
  input  logic           eng_clr_en
);
  logic [AW-1:0] src_q  [NCH];
  logic [AW-1:0] dst_q  [NCH];
  logic [AW-1:0] lli_q  [NCH];
  logic [DW-1:0] ctrl_q [NCH];
  logic [NCH-1:0] en_q;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic eng_hit, sw_hit;
    assign eng_hit = (act_ch == CHW'(i));
    assign sw_hit  = sw_we && (sw_ch == CHW'(i)) && !(busy && eng_hit);

    always_ff @(posedge clk) begin
      if (rst) begin
        src_q[i]  <= '0;
        dst_q[i]  <= '0;
        lli_q[i]  <= '0;
        ctrl_q[i] <= '0;
        en_q[i]   <= 1'b0;
      end else if (sw_hit) begin
        case (sw_sel)
          SEL_SRC:  src_q[i]  <= AW'(sw_wdata);
          SEL_DST:  dst_q[i]  <= AW'(sw_wdata);
          SEL_LINK: lli_q[i]  <= AW'(sw_wdata);
          SEL_CTRL: ctrl_q[i] <= sw_wdata;
          SEL_EN:   en_q[i]   <= sw_wdata[0];
          default: ;
        endcase
      end else if (eng_hit) begin
        if (eng_we_src)  src_q[i]  <= eng_src;
        if (eng_we_dst)  dst_q[i]  <= eng_dst;
        if (eng_we_lli)  lli_q[i]  <= eng_lli;
        if (eng_we_ctrl) ctrl_q[i] <= eng_ctrl;
        if (eng_clr_en)  en_q[i]   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sw_rdata <= '0;
    else begin
      case (sw_sel)
        SEL_SRC:  sw_rdata <= DW'(src_q[sw_ch]);
        SEL_DST:  sw_rdata <= DW'(dst_q[sw_ch]);
        SEL_LINK: sw_rdata <= DW'(lli_q[sw_ch]);
        SEL_CTRL: sw_rdata <= ctrl_q[sw_ch];
        SEL_EN:   sw_rdata <= DW'(en_q[sw_ch]);
        default:  sw_rdata <= '0;
      endcase
    end
  end

  assign look_src  = src_q[look_ch];
  assign look_dst  = dst_q[look_ch];
  assign look_lli  = lli_q[look_ch];
  assign look_ctrl = ctrl_q[look_ch];
  assign look_en   = en_q[look_ch];
  assign en_vec    = en_q;
endmodule

// File: rtl/lldma_ctrl.sv
module lldma_ctrl
  import lldma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 32,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           grant_valid,
  input  logic [CHW-1:0] grant_chan,
  output logic [CHW-1:0] look_ch,
  output logic [CHW-1:0] act_ch,
  input  logic [AW-1:0]  look_src,
  input  logic [AW-1:0]  look_dst,
  input  logic [AW-1:0]  look_lli,
  input  logic [DW-1:0]  look_ctrl,
  input  logic           look_en,
  output logic           busy,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [1:0]     mem_size,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ack,
  input  logic           mem_err,
  output logic           eng_we_src,
  output logic [AW-1:0]  eng_src,
  output logic           eng_we_dst,
  output logic [AW-1:0]  eng_dst,
  output logic           eng_we_ctrl,
  output logic [DW-1:0]  eng_ctrl,
  output logic           eng_we_lli,
  output logic [AW-1:0]  eng_lli,
  output logic           eng_clr_en,
  output logic [NCH-1:0] tc_set,
  output logic [NCH-1:0] err_set
);
  lldma_state_e state_q;
  logic [CHW-1:0] ch_q;
  logic [1:0] s_code, d_code;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0] rd_lane, wr_lane;
  logic ok_ack, bad_ack, last_elem;

  assign look_ch   = (state_q == ST_IDLE) ? grant_chan : ch_q;
  assign act_ch    = ch_q;
  assign busy      = (state_q != ST_IDLE);
  assign s_code    = clamp_size(look_ctrl[SSZ_LSB +: 3]);
  assign d_code    = clamp_size(look_ctrl[DSZ_LSB +: 3]);
  assign cnt       = look_ctrl[CNT_W-1:0];
  assign ok_ack    = mem_ack && !mem_err;
  assign bad_ack   = mem_ack && mem_err;
  assign last_elem = (cnt == CNT_W'(1));

  lldma_lane u_rd_lane (.size_code(s_code), .din(mem_rdata), .dout(rd_lane));
  lldma_lane u_wr_lane (.size_code(d_code), .din(rd_lane),   .dout(wr_lane));

  always_comb begin
    eng_we_src  = 1'b0;
    eng_we_dst  = 1'b0;
    eng_we_ctrl = 1'b0;
    eng_we_lli  = 1'b0;
    eng_clr_en  = 1'b0;
    eng_src  = (state_q == ST_FETCH0) ? AW'(mem_rdata)
             : look_src + (look_ctrl[SINC_BIT] ? AW'(size_bytes(s_code)) : '0);
    eng_dst  = (state_q == ST_FETCH1) ? AW'(mem_rdata)
             : look_dst + (look_ctrl[DINC_BIT] ? AW'(size_bytes(d_code)) : '0);
    eng_ctrl = (state_q == ST_FETCH2) ? mem_rdata
             : {look_ctrl[DW-1:CNT_W], cnt - CNT_W'(1)};
    eng_lli  = AW'(mem_rdata);
    case (state_q)
      ST_READ, ST_WRITE: eng_clr_en = bad_ack;
      ST_UPDATE: begin
        eng_we_src  = 1'b1;
        eng_we_dst  = 1'b1;
        eng_we_ctrl = 1'b1;
        eng_clr_en  = last_elem && (look_lli == '0);
      end
      ST_FETCH0: begin eng_we_src  = ok_ack; eng_clr_en = bad_ack; end
      ST_FETCH1: begin eng_we_dst  = ok_ack; eng_clr_en = bad_ack; end
      ST_FETCH2: begin eng_we_ctrl = ok_ack; eng_clr_en = bad_ack; end
      ST_FETCH3: begin eng_we_lli  = ok_ack; eng_clr_en = bad_ack; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ch_q      <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_size  <= '0;
      mem_wdata <= '0;
      tc_set    <= '0;
      err_set   <= '0;
    end else begin
      tc_set  <= '0;
      err_set <= '0;
      if (bad_ack && (state_q == ST_READ || state_q == ST_WRITE ||
                      state_q == ST_FETCH0 || state_q == ST_FETCH1 ||
                      state_q == ST_FETCH2 || state_q == ST_FETCH3)) begin
        mem_req <= 1'b0;
        mem_we  <= 1'b0;
        err_set <= NCH'(1) << ch_q;
        state_q <= ST_DONE;
      end else begin
        case (state_q)
          ST_IDLE: if (grant_valid && look_en && cnt != '0) begin
            ch_q     <= grant_chan;
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= look_src;
            mem_size <= s_code;
            state_q  <= ST_READ;
          end
          ST_READ: if (mem_ack) begin
            mem_we    <= 1'b1;
            mem_addr  <= look_dst;
            mem_size  <= d_code;
            mem_wdata <= wr_lane;
            state_q   <= ST_WRITE;
          end
          ST_WRITE: if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            state_q <= ST_UPDATE;
          end
          ST_UPDATE: begin
            state_q <= ST_DONE;
            if (last_elem) begin
              if (look_ctrl[TCF_BIT]) tc_set <= NCH'(1) << ch_q;
              if (look_lli != '0) begin
                mem_req  <= 1'b1;
                mem_addr <= look_lli;
                mem_size <= 2'd2;
                state_q  <= ST_FETCH0;
              end
            end
          end
          ST_FETCH0: if (mem_ack) begin
            mem_addr <= look_lli + AW'(4);
            state_q  <= ST_FETCH1;
          end
          ST_FETCH1: if (mem_ack) begin
            mem_addr <= look_lli + AW'(12);
            state_q  <= ST_FETCH2;
          end
          ST_FETCH2: if (mem_ack) begin
            mem_addr <= look_lli + AW'(8);
            state_q  <= ST_FETCH3;
          end
          ST_FETCH3: if (mem_ack) begin
            mem_req <= 1'b0;
            state_q <= ST_DONE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lldma_engine.sv
module lldma_engine
  import lldma_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           grant_valid,
  input  logic [CHW-1:0] grant_chan,
  output logic           busy,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_chan,
  input  logic [2:0]     cfg_sel,
  input  logic [31:0]    cfg_wdata,
  output logic [31:0]    cfg_rdata,
  output logic [NCH-1:0] chan_en,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [1:0]     mem_size,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata,
  input  logic           mem_ack,
  input  logic           mem_err,
  output logic [NCH-1:0] tc_set,
  output logic [NCH-1:0] err_set
);
  logic [CHW-1:0] look_ch, act_ch;
  logic [AW-1:0]  look_src, look_dst, look_lli;
  logic [DW-1:0]  look_ctrl;
  logic           look_en;
  logic           we_src, we_dst, we_ctrl, we_lli, clr_en;
  logic [AW-1:0]  e_src, e_dst, e_lli;
  logic [DW-1:0]  e_ctrl;

  lldma_regfile #(.NCH(NCH), .AW(AW), .CHW(CHW)) u_regs (
    .clk, .rst,
    .sw_we(cfg_we), .sw_ch(cfg_chan), .sw_sel(cfg_sel),
    .sw_wdata(cfg_wdata), .sw_rdata(cfg_rdata),
    .busy, .act_ch, .look_ch,
    .look_src, .look_dst, .look_lli, .look_ctrl, .look_en,
    .en_vec(chan_en),
    .eng_we_src(we_src), .eng_src(e_src),
    .eng_we_dst(we_dst), .eng_dst(e_dst),
    .eng_we_ctrl(we_ctrl), .eng_ctrl(e_ctrl),
    .eng_we_lli(we_lli), .eng_lli(e_lli),
    .eng_clr_en(clr_en)
  );

  lldma_ctrl #(.NCH(NCH), .AW(AW), .CHW(CHW)) u_ctrl (
    .clk, .rst, .grant_valid, .grant_chan,
    .look_ch, .act_ch,
    .look_src, .look_dst, .look_lli, .look_ctrl, .look_en,
    .busy,
    .mem_req, .mem_we, .mem_addr, .mem_size, .mem_wdata,
    .mem_rdata, .mem_ack, .mem_err,
    .eng_we_src(we_src), .eng_src(e_src),
    .eng_we_dst(we_dst), .eng_dst(e_dst),
    .eng_we_ctrl(we_ctrl), .eng_ctrl(e_ctrl),
    .eng_we_lli(we_lli), .eng_lli(e_lli),
    .eng_clr_en(clr_en),
    .tc_set, .err_set
  );
endmodule

// File: rtl/lldma_engine_chk.sv
module lldma_engine_chk #(
  parameter int NCH = 8,
  parameter int AW  = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           busy,
  input logic           mem_req,
  input logic           mem_we,
  input logic [AW-1:0]  mem_addr,
  input logic [1:0]     mem_size,
  input logic           mem_ack,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] tc_set,
  input logic [NCH-1:0] err_set
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R11
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_size != 2'd3)); // R3
  AST_TC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tc_set)); // R8
  AST_TC_IN_SERVICE: assert property (@(posedge clk) disable iff (rst)
    (tc_set != '0) |-> busy); // R8
  AST_ERR_DISABLES: assert property (@(posedge clk) disable iff (rst)
    (err_set != '0) |-> ((err_set & chan_en) == '0)); // R9
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(err_set)); // R9
endmodule

bind lldma_engine lldma_engine_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_size(mem_size), .mem_ack(mem_ack),
  .chan_en(chan_en), .tc_set(tc_set), .err_set(err_set)
);

// File: tb/lldma_engine_test.sv
`timescale 1ns/1ps
module lldma_engine_test;
  localparam int NCH = 8;
  localparam int CHW = 3;
  localparam int MSZ = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic grant_valid = 1'b0;
  logic [CHW-1:0] grant_chan = '0;
  logic busy;
  logic cfg_we = 1'b0;
  logic [CHW-1:0] cfg_chan = '0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [NCH-1:0] chan_en, tc_set, err_set;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0] mem_size;
  logic [31:0] mem_rdata = '0;
  logic mem_ack = 1'b0;
  logic mem_err = 1'b0;

  lldma_engine #(.NCH(NCH), .AW(32)) uut (
    .clk, .rst, .grant_valid, .grant_chan, .busy,
    .cfg_we, .cfg_chan, .cfg_sel, .cfg_wdata, .cfg_rdata, .chan_en,
    .mem_req, .mem_we, .mem_addr, .mem_size, .mem_wdata,
    .mem_rdata, .mem_ack, .mem_err, .tc_set, .err_set
  );

  always #4 clk = ~clk;

  logic [7:0]  mem [MSZ];
  logic [31:0] log_addr [64];
  int log_n = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  int tc_cnt [NCH];
  int err_cnt [NCH];
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // memory slave: ack one cycle after a request, then drop the ack
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mem_ack) begin
        mem_ack = 1'b0;
        mem_err = 1'b0;
      end else if (mem_req) begin
        if (log_n < 64) log_addr[log_n] = mem_addr;
        log_n++;
        mem_err = (mem_addr == err_addr);
        if (mem_we && !mem_err) begin
          for (int b = 0; b < (1 << mem_size); b++)
            mem[(mem_addr + b) % MSZ] = mem_wdata[8*b +: 8];
        end else begin
          mem_rdata = '0;
          for (int b = 0; b < (1 << mem_size); b++)
            mem_rdata[8*b +: 8] = mem[(mem_addr + b) % MSZ];
        end
        mem_ack = 1'b1;
      end
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin tc_cnt[i] = 0; err_cnt[i] = 0; end
    forever begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
        tc_cnt[i]  += int'(tc_set[i]);
        err_cnt[i] += int'(err_set[i]);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input int cnt, input int sw, input int dw,
                                          input bit si, input bit di, input bit tc);
    return 32'(cnt & 12'hFFF) | (32'(sw) << 18) | (32'(dw) << 21) |
           (32'(si) << 26) | (32'(di) << 27) | (32'(tc) << 31);
  endfunction

  function automatic int nbytes(input int code);
    return (code > 2) ? 4 : (1 << code);
  endfunction

  function automatic logic [31:0] get_bytes(input logic [31:0] a, input int n);
    logic [31:0] v = '0;
    for (int b = 0; b < n; b++) v[8*b +: 8] = mem[(a + b) % MSZ];
    return v;
  endfunction

  task automatic put32(input logic [31:0] a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[(a + b) % MSZ] = v[8*b +: 8];
  endtask

  task automatic wr_reg(input int ch, input int sel, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_chan = CHW'(ch); cfg_sel = 3'(sel); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input int ch, input int sel, output logic [31:0] v);
    @(negedge clk);
    cfg_chan = CHW'(ch); cfg_sel = 3'(sel);
    @(negedge clk);
    v = cfg_rdata;
  endtask

  task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] d,
                       input logic [31:0] l, input logic [31:0] c, input bit en);
    wr_reg(ch, 0, s); wr_reg(ch, 1, d); wr_reg(ch, 2, l);
    wr_reg(ch, 3, c); wr_reg(ch, 4, 32'(en));
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 200) begin @(negedge clk); guard++; end
  endtask

  task automatic grant(input int ch, output bit taken);
    @(negedge clk);
    log_n = 0;
    grant_valid = 1'b1; grant_chan = CHW'(ch);
    @(negedge clk);
    grant_valid = 1'b0;
    taken = busy;
    wait_idle();
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, exp_src, exp_dst, exp_data, ctl;
    bit taken;
    void'($urandom(32'd20240611));
    for (int i = 0; i < MSZ; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 mem_req", 32'(mem_req), 32'd0);
    chk("R1 chan_en", 32'(chan_en), 32'd0);
    chk("R1 tc_set", 32'(tc_set | err_set), 32'd0);
    rd_reg(0, 3, v); chk("R1 ctrl", v, 32'd0);
    rd_reg(7, 0, v); chk("R1 src", v, 32'd0);

    // R3 R4 R5: equal widths of 1, 2 and 4 bytes, three elements each
    for (int w = 0; w < 3; w++) begin
      exp_src = 32'h100 + 32'(w * 32);
      exp_dst = 32'h200 + 32'(w * 32);
      ctl = mk_ctrl(3, w, w, 1, 1, 0);
      setup(w, exp_src, exp_dst, 0, ctl, 1);
      for (int e = 0; e < 3; e++) begin
        exp_data = get_bytes(exp_src, nbytes(w));
        grant(w, taken);
        chk("R11 taken", 32'(taken), 32'd1);
        chk("R3 data", get_bytes(exp_dst, nbytes(w)), exp_data);
        chk("R3 two accesses", 32'(log_n), 32'd2);
        exp_src += 32'(nbytes(w)); exp_dst += 32'(nbytes(w));
        rd_reg(w, 0, v); chk("R4 src", v, exp_src);
        rd_reg(w, 1, v); chk("R4 dst", v, exp_dst);
        rd_reg(w, 3, v); chk("R5 ctrl", v, (ctl & 32'hFFFF_F000) | 32'(2 - e));
      end
      chk("R7 disabled at end", 32'(chan_en[w]), 32'd0);
      chk("R8 no tc without flag", 32'(tc_cnt[w]), 32'd0);
    end

    // R2: disabled channel and zero count are ignored
    setup(4, 32'h40, 32'h240, 0, mk_ctrl(2, 2, 2, 1, 1, 0), 0);
    grant(4, taken);
    chk("R2 disabled not taken", 32'(taken), 32'd0);
    chk("R2 no access", 32'(log_n), 32'd0);
    rd_reg(4, 0, v); chk("R2 src kept", v, 32'h40);
    setup(4, 32'h40, 32'h240, 0, mk_ctrl(0, 2, 2, 1, 1, 0), 1);
    grant(4, taken);
    chk("R2 zero count not taken", 32'(taken), 32'd0);
    chk("R2 still enabled", 32'(chan_en[4]), 32'd1);

    // R3: oversize code treated as 4 bytes; R4: no increment
    exp_data = get_bytes(32'h60, 4);
    setup(4, 32'h60, 32'h260, 0, mk_ctrl(2, 6, 5, 0, 0, 0), 1);
    grant(4, taken);
    chk("R3 clamp data", get_bytes(32'h260, 4), exp_data);
    rd_reg(4, 0, v); chk("R4 src fixed", v, 32'h60);
    rd_reg(4, 1, v); chk("R4 dst fixed", v, 32'h260);

    // R6 R8: linked list reload
    put32(32'h300, 32'h0A0);
    put32(32'h304, 32'h2A0);
    put32(32'h308, 32'h0);
    put32(32'h30C, mk_ctrl(2, 2, 2, 1, 1, 1));
    setup(3, 32'h80, 32'h280, 32'h300, mk_ctrl(1, 2, 2, 1, 1, 1), 1);
    grant(3, taken);
    chk("R6 access count", 32'(log_n), 32'd6);
    chk("R6 order 0", log_addr[2], 32'h300);
    chk("R6 order 1", log_addr[3], 32'h304);
    chk("R6 order 2", log_addr[4], 32'h30C);
    chk("R6 order 3", log_addr[5], 32'h308);
    rd_reg(3, 0, v); chk("R6 src", v, 32'h0A0);
    rd_reg(3, 1, v); chk("R6 dst", v, 32'h2A0);
    rd_reg(3, 3, v); chk("R6 ctrl", v, mk_ctrl(2, 2, 2, 1, 1, 1));
    rd_reg(3, 2, v); chk("R6 link", v, 32'h0);
    chk("R6 still enabled", 32'(chan_en[3]), 32'd1);
    chk("R8 tc pulse", 32'(tc_cnt[3]), 32'd1);
    grant(3, taken);
    grant(3, taken);
    chk("R7 chain end", 32'(chan_en[3]), 32'd0);
    chk("R8 second tc", 32'(tc_cnt[3]), 32'd2);

    // R9: error on the source read
    err_addr = 32'h0C0;
    setup(2, 32'h0C0, 32'h2C0, 0, mk_ctrl(3, 2, 2, 1, 1, 1), 1);
    grant(2, taken);
    chk("R9 one access", 32'(log_n), 32'd1);
    chk("R9 err pulse", 32'(err_cnt[2]), 32'd1);
    chk("R9 disabled", 32'(chan_en[2]), 32'd0);
    rd_reg(2, 3, v); chk("R9 count kept", v, mk_ctrl(3, 2, 2, 1, 1, 1));
    err_addr = 32'hFFFF_FFFF;

    // R10: write to serviced channel dropped, other channel accepted
    setup(5, 32'h20, 32'h220, 0, mk_ctrl(2, 2, 2, 1, 1, 0), 1);
    @(negedge clk);
    grant_valid = 1'b1; grant_chan = 3'd5;
    @(negedge clk);
    grant_valid = 1'b0;
    cfg_we = 1'b1; cfg_chan = 3'd5; cfg_sel = 3'd0; cfg_wdata = 32'h3F0;
    @(negedge clk);
    cfg_chan = 3'd6; cfg_wdata = 32'h055;
    @(negedge clk);
    cfg_we = 1'b0;
    wait_idle();
    rd_reg(5, 0, v); chk("R10 busy write dropped", v, 32'h24);
    rd_reg(6, 0, v); chk("R10 other channel written", v, 32'h055);

    // random elements
    for (int it = 0; it < 24; it++) begin
      int ch, w, c;
      bit si, di;
      ch = int'($urandom % NCH); w = int'($urandom % 3);
      c = 2 + int'($urandom % 6);
      si = 1'($urandom); di = 1'($urandom);
      exp_src = 32'($urandom % 64) * 4;
      exp_dst = 32'h200 + 32'($urandom % 64) * 4;
      ctl = mk_ctrl(c, w, w, si, di, 1);
      setup(ch, exp_src, exp_dst, 0, ctl, 1);
      exp_data = get_bytes(exp_src, nbytes(w));
      grant(ch, taken);
      chk("R3 random data", get_bytes(exp_dst, nbytes(w)), exp_data);
      rd_reg(ch, 0, v); chk("R4 random src", v, exp_src + (si ? 32'(nbytes(w)) : 0));
      rd_reg(ch, 1, v); chk("R4 random dst", v, exp_dst + (di ? 32'(nbytes(w)) : 0));
      rd_reg(ch, 3, v); chk("R5 random ctrl", v, (ctl & 32'hFFFF_F000) | 32'(c - 1));
    end

    chk("R11 idle at end", 32'(busy), 32'd0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule